// File: doc/BRIEF.md
# Timer Compare Channel with Match Actions

This block is a single compare channel. It watches one of two free-running timers, the reference timer, and signals an event when that timer's value equals a programmed compare value. An 8-bit control byte chooses the reference timer. It also turns the channel on, chooses what a match does to the timers and chooses whether a match starts an external converter.

On a match the channel can reset nothing, reset the reference timer, or reset the other (opposite) timer. The timers act on these requests themselves. A match can also send a start pulse to an external converter, but only when an external select input names this channel as the conversion source. Every match also pulses an interrupt-pending set strobe. An interrupt mask further along the chain does not affect this strobe.

Each output is a single-cycle pulse. It is registered on the clock edge at which the equality is present. A match fires once for each timer value: if the timer stays at the matching value, no further events follow until the timer has moved away and come back.

Top module: `tcc_top`

## Requirements
- R1: During synchronous reset, and right after it with the control byte at 00h, every output (match_evt, pend_set, rst_timer_a, rst_timer_b, conv_start) is 0.
- R2: With control bit 6 (compare enable) at 1, match_evt is 1 in the cycle after an edge at which the reference timer equals cmp_val. Control bit 7 selects the reference timer: 0 selects timer_a and 1 selects timer_b. The value of the non-selected timer causes no event.
- R3: With control bit 6 at 0, no output ever pulses, whatever the timer values are.
- R4: With control bit 0 (reset enable) at 0, a match pulses neither rst_timer_a nor rst_timer_b, whatever control bit 1 holds.
- R5: With bit 0 at 1 and bit 1 (opposite select) at 0, a match pulses the reset request of the reference timer only: rst_timer_a when bit 7 is 0, rst_timer_b when bit 7 is 1.
- R6: With bit 0 at 1 and bit 1 at 1, a match pulses the reset request of the opposite timer only: rst_timer_b when bit 7 is 0, rst_timer_a when bit 7 is 1.
- R7: conv_start pulses together with match_evt only when control bit 2 (converter trigger) is 1 and conv_src_sel is 1 at the matching edge. Otherwise conv_start stays 0.
- R8: pend_set pulses in exactly the cycles in which match_evt pulses.
- R9: While the reference timer holds the matching value over consecutive edges, only one event is produced. A new event needs a match on a changed timer value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_a | input | TW | Value of timer A |
| timer_b | input | TW | Value of timer B |
| cmp_val | input | TW | Programmed compare value |
| ctrl | input | 8 | Control byte: bit 7 timer select, bit 6 compare enable, bit 2 converter trigger, bit 1 opposite select, bit 0 reset enable |
| conv_src_sel | input | 1 | High when this channel is the converter's start source |
| match_evt | output | 1 | Single-cycle match event |
| pend_set | output | 1 | Single-cycle interrupt-pending set strobe |
| rst_timer_a | output | 1 | Single-cycle reset request to timer A |
| rst_timer_b | output | 1 | Single-cycle reset request to timer B |
| conv_start | output | 1 | Single-cycle converter start pulse |

## Verification
Corrupted hold-off state, meaning a wrong remembered timer value or a wrong remembered equality flag, appears at the ports in the very next cycle. It shows either as a repeated event while the timer rests on the compare value or as a missing event when the timer comes back to it. A wrong decode of the reference or opposite timer shows up on the first match with reset enabled, as a pulse on the wrong reset line. Each stimulus step is therefore checked one cycle after its matching edge, on all five outputs together. The sequences cover held values, both timer selections and every combination of the action bits.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    localparam int CTRL_W = 8;

    typedef struct packed {
        logic       tsel;      // 0: timer A is reference, 1: timer B
        logic       cmp_en;    // compare enable
        logic [2:0] spare;     // unused
        logic       conv_en;   // converter trigger
        logic       opp_sel;   // reset opposite instead of reference
        logic       rst_en;    // reset enable
    } ctrl_t;

    typedef struct packed {
        logic match;
        logic pend;
        logic rst_a;
        logic rst_b;
        logic conv;
    } evt_t;

    localparam evt_t EVT_IDLE = '{default: 1'b0};

    // Returns {reset A, reset B} for a given control setting.
    function automatic logic [1:0] reset_targets(input ctrl_t c);
        logic reset_ref_a;
        reset_ref_a = (c.tsel == 1'b0) ^ c.opp_sel;
        if (!c.rst_en) begin
            return 2'b00;
        end
        return reset_ref_a ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/tcc_detect.sv
module tcc_detect #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [TW-1:0] ref_val,
    input  logic [TW-1:0] cmp_val,
    output logic          hit
);
    logic          eq_now;
    logic          prev_eq;
    logic [TW-1:0] prev_val;
    logic          fresh;

    assign eq_now = en && (ref_val == cmp_val);
    assign fresh  = !(prev_eq && (ref_val == prev_val));
    assign hit    = eq_now && fresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_eq  <= 1'b0;
            prev_val <= '0;
        end else begin
            prev_eq  <= eq_now;
            prev_val <= ref_val;
        end
    end

    // R9
    hold_once_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> !(hit && $stable(ref_val)));

endmodule

// File: rtl/tcc_action.sv
module tcc_action
    import tcc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hit,
    input  ctrl_t ctrl,
    input  logic  conv_src_sel,
    output evt_t  evt
);
    evt_t      nxt;
    logic [1:0] tgt;

    always_comb begin
        tgt       = reset_targets(ctrl);
        nxt       = EVT_IDLE;
        nxt.match = hit;
        nxt.pend  = hit;
        nxt.rst_a = hit && tgt[1];
        nxt.rst_b = hit && tgt[0];
        nxt.conv  = hit && ctrl.conv_en && conv_src_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt <= EVT_IDLE;
        end else begin
            evt <= nxt;
        end
    end

    // R4
    no_reset_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.rst_a || evt.rst_b) |-> $past(ctrl.rst_en));

    // R5
    single_reset_chk: assert property (@(posedge clk) disable iff (rst)
        !(evt.rst_a && evt.rst_b));

    // R7
    conv_needs_src_chk: assert property (@(posedge clk) disable iff (rst)
        evt.conv |-> ($past(conv_src_sel) && $past(ctrl.conv_en) && evt.match));

    // R8
    pend_follows_match_chk: assert property (@(posedge clk) disable iff (rst)
        evt.pend == evt.match);

endmodule

// File: rtl/tcc_top.sv
module tcc_top
    import tcc_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] timer_a,
    input  logic [TW-1:0] timer_b,
    input  logic [TW-1:0] cmp_val,
    input  logic [7:0]    ctrl,
    input  logic          conv_src_sel,
    output logic          match_evt,
    output logic          pend_set,
    output logic          rst_timer_a,
    output logic          rst_timer_b,
    output logic          conv_start
);
    ctrl_t         c;
    logic [TW-1:0] ref_val;
    logic          hit;
    evt_t          evt;

    assign c       = ctrl_t'(ctrl);
    assign ref_val = c.tsel ? timer_b : timer_a;

    tcc_detect #(.TW(TW)) detect_i (
        .clk     (clk),
        .rst     (rst),
        .en      (c.cmp_en),
        .ref_val (ref_val),
        .cmp_val (cmp_val),
        .hit     (hit)
    );

    tcc_action action_i (
        .clk          (clk),
        .rst          (rst),
        .hit          (hit),
        .ctrl         (c),
        .conv_src_sel (conv_src_sel),
        .evt          (evt)
    );

    assign match_evt   = evt.match;
    assign pend_set    = evt.pend;
    assign rst_timer_a = evt.rst_a;
    assign rst_timer_b = evt.rst_b;
    assign conv_start  = evt.conv;

    // R3
    enable_gates_chk: assert property (@(posedge clk) disable iff (rst)
        match_evt |-> $past(ctrl[6]));

    // R2
    match_is_equal_chk: assert property (@(posedge clk) disable iff (rst)
        match_evt |-> $past((ctrl[7] ? timer_b : timer_a) == cmp_val));

endmodule

// File: tb/tcc_top_tb_top.sv
module tcc_top_tb_top;
    localparam int TW = 16;

    typedef struct {
        logic [4:0] v;   // {match, pend, rst_a, rst_b, conv}
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] timer_a = '0, timer_b = '0, cmp_val = '0;
    logic [7:0]    ctrl = 8'h00;
    logic          conv_src_sel = 1'b0;
    logic          match_evt, pend_set, rst_timer_a, rst_timer_b, conv_start;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    bit   m_prev_eq = 1'b0;
    logic [TW-1:0] m_prev_val = '0;

    always #4 clk = ~clk;

    tcc_top #(.TW(TW)) dut_i (
        .clk(clk), .rst(rst), .timer_a(timer_a), .timer_b(timer_b),
        .cmp_val(cmp_val), .ctrl(ctrl), .conv_src_sel(conv_src_sel),
        .match_evt(match_evt), .pend_set(pend_set), .rst_timer_a(rst_timer_a),
        .rst_timer_b(rst_timer_b), .conv_start(conv_start)
    );

    function automatic logic [4:0] outs();
        return {match_evt, pend_set, rst_timer_a, rst_timer_b, conv_start};
    endfunction

    task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Driver: apply one step at the falling edge and push the expected outputs.
    task automatic step(input logic [TW-1:0] ta, input logic [TW-1:0] tb,
                        input logic [TW-1:0] cv, input logic [7:0] cb,
                        input logic sel, input string tag);
        exp_t e;
        logic [TW-1:0] r;
        bit eqn, hit;
        @(negedge clk);
        timer_a = ta; timer_b = tb; cmp_val = cv; ctrl = cb; conv_src_sel = sel;
        r   = cb[7] ? tb : ta;
        eqn = cb[6] && (r == cv);
        hit = eqn && !(m_prev_eq && (r == m_prev_val));
        m_prev_eq  = eqn;
        m_prev_val = r;
        e.v[4] = hit;
        e.v[3] = hit;
        e.v[2] = hit && cb[0] && (cb[1] ? cb[7] : !cb[7]);
        e.v[1] = hit && cb[0] && (cb[1] ? !cb[7] : cb[7]);
        e.v[0] = hit && cb[2] && sel;
        e.tag  = tag;
        q.push_back(e);
    endtask

    // Monitor: compare after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(outs(), e.v, e.tag);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: outputs held low in reset, even with matching inputs enabled
        @(negedge clk);
        timer_a = 16'h0010; cmp_val = 16'h0010; ctrl = 8'h47; conv_src_sel = 1'b1;
        @(negedge clk);
        check(outs(), 5'b0, "R1 during reset");
        ctrl = 8'h00; timer_a = 16'h0000;
        rst = 1'b0;
        @(negedge clk);
        check(outs(), 5'b0, "R1 after reset");

        // R2: timer A reference, basic match
        step(16'h0005, 16'h0100, 16'h0100, 8'h40, 1'b0, "R2 A ref, B equal ignored");
        step(16'h0100, 16'h0000, 16'h0100, 8'h40, 1'b0, "R2 A ref match");
        step(16'h0101, 16'h0000, 16'h0100, 8'h40, 1'b0, "R2 A moved on");
        // R2: timer B reference
        step(16'h0200, 16'h0001, 16'h0200, 8'hC0, 1'b0, "R2 B ref, A equal ignored");
        step(16'h0000, 16'h0200, 16'h0200, 8'hC0, 1'b0, "R2 B ref match");
        // R9: hold the matching value
        step(16'h0000, 16'h0200, 16'h0200, 8'hC0, 1'b0, "R9 hold 1");
        step(16'h0000, 16'h0200, 16'h0200, 8'hC0, 1'b0, "R9 hold 2");
        step(16'h0000, 16'h0201, 16'h0200, 8'hC0, 1'b0, "R9 leave");
        step(16'h0000, 16'h0200, 16'h0200, 8'hC0, 1'b0, "R9 return refires");
        // R3: compare disabled
        step(16'h0300, 16'h0300, 16'h0300, 8'h07, 1'b1, "R3 disabled A");
        step(16'h0300, 16'h0300, 16'h0300, 8'h87, 1'b1, "R3 disabled B");
        step(16'h0301, 16'h0301, 16'h0300, 8'h47, 1'b1, "R3 idle");
        // R4: reset enable off, opposite bit set or not
        step(16'h0400, 16'h0, 16'h0400, 8'h42, 1'b0, "R4 opp=1 rst_en=0");
        step(16'h0401, 16'h0, 16'h0401, 8'h40, 1'b0, "R4 opp=0 rst_en=0");
        // R5: reset reference
        step(16'h0500, 16'h0, 16'h0500, 8'h41, 1'b0, "R5 reset ref A");
        step(16'h0, 16'h0501, 16'h0501, 8'hC1, 1'b0, "R5 reset ref B");
        // R6: reset opposite
        step(16'h0600, 16'h0, 16'h0600, 8'h43, 1'b0, "R6 reset opp B");
        step(16'h0, 16'h0601, 16'h0601, 8'hC3, 1'b0, "R6 reset opp A");
        // R7: converter start gating
        step(16'h0700, 16'h0, 16'h0700, 8'h44, 1'b1, "R7 conv on, selected");
        step(16'h0701, 16'h0, 16'h0701, 8'h44, 1'b0, "R7 conv on, not selected");
        step(16'h0702, 16'h0, 16'h0702, 8'h40, 1'b1, "R7 conv off, selected");
        step(16'h0, 16'h0703, 16'h0703, 8'hC7, 1'b1, "R7 all actions B ref");
        // R8: pend tracks matches over a counting timer
        for (int i = 0; i < 6; i++) begin
            step(16'h0800 + 16'(i), 16'h0, 16'h0803, 8'h44, 1'b1, "R8 counting");
        end
        // R9 with B after A select change
        step(16'h0900, 16'h0900, 16'h0900, 8'h40, 1'b0, "R9 A match");
        step(16'h0900, 16'h0900, 16'h0900, 8'hC0, 1'b0, "R9 switch to equal B");
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule